// File: doc/BRIEF.md
# Real-Time Clock Interrupt Unit

This block is the interrupt part of a real-time clock. It counts cycles of a 32.768 kHz time base, which arrives as a one-cycle enable pulse in the system clock domain. A 4-bit rate code picks a power-of-two periodic interval. The same interval drives an optional square-wave output.

Three event sources feed sticky flags: the periodic divider, an alarm-match pulse and an update-ended pulse. A read-only status byte shows these flags. A summary bit in that byte is set when any flag is set and its own enable is also set, and that summary bit drives the interrupt request. Reading the status byte clears it. The time counting and the register access port sit outside this block, which takes the control fields as plain inputs.

Top module: `rtc_irq_unit`

## Requirements
- R1: The divider runs only while `div_sel` equals 3'b010. With any other value the tick counter is held at zero and there are no periodic or square-wave events.
- R2: Rate code 4'b0000 produces no periodic events.
- R3: For rate codes 3 to 15, the periodic interval is 2^(code-1) base ticks. The first periodic event comes on tick number 2^(code-1) after the divider starts from zero: 4 ticks for code 3 and 16384 ticks for code 15.
- R4: Rate codes 1 and 2 give the same intervals as codes 8 and 9, which are 128 and 256 ticks.
- R5: In `flag_reg`, bit 6 is the periodic flag, bit 5 the alarm flag and bit 4 the update-ended flag. Each flag is set by its event whatever the enables are, and it stays set until a status read.
- R6: `flag_reg` bit 7 and `irq` are both high when (bit6 & `per_en`) | (bit5 & `alm_en`) | (bit4 & `upd_en`) is true. They follow an enable that changes while a flag is set.
- R7: `flag_reg` bits 3:0 always read as zero.
- R8: A clock cycle with `flag_rd` high returns the current byte and then clears every flag and `irq`. An event that arrives in that same cycle is kept.
- R9: `sqw` toggles every half periodic interval, so its full period is one periodic interval. It is held low while `sqw_en` is low, while the rate code is 0, or while the divider is stopped.
- R10: After reset, `flag_reg`, `irq` and `sqw` are all zero and the tick counter is zero.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst | input | 1 | Synchronous active-high reset |
| base_tick | input | 1 | One-cycle pulse per cycle of the 32.768 kHz time base |
| alarm_evt | input | 1 | Alarm-match event pulse |
| update_evt | input | 1 | Update-ended event pulse |
| div_sel | input | 3 | Divider chain select (3'b010 = run) |
| rate_code | input | 4 | Periodic rate code |
| per_en | input | 1 | Periodic interrupt enable |
| alm_en | input | 1 | Alarm interrupt enable |
| upd_en | input | 1 | Update-ended interrupt enable |
| sqw_en | input | 1 | Square-wave output enable |
| flag_rd | input | 1 | Status byte read strobe (clear on read) |
| flag_reg | output | 8 | Status byte: {irq, periodic, alarm, update, 4'b0} |
| irq | output | 1 | Interrupt request |
| sqw | output | 1 | Square-wave output |

## Verification
The bench uses the default parameters: a 15-bit tick counter and run select 3'b010. These defaults put every rate code within reach, including the longest interval of code 15 at 16384 ticks. For each code under test the bench checks the tick just before the first periodic event and the tick on which it lands. It also covers the folded codes 1 and 2, the stopped divider, the square-wave phases, and a status read that coincides with an alarm event.

// File: rtl/rtc_irq_pkg.sv
package rtc_irq_pkg;

  localparam int RATE_W = 4;
  localparam int EXP_W  = 4;

  typedef struct packed {
    logic per;
    logic alm;
    logic upd;
  } evt_flags_t;

  // Divider exponent for a rate code; 0 means periodic output is off.
  function automatic logic [EXP_W-1:0] rate_exp(input logic [RATE_W-1:0] code);
    logic [EXP_W-1:0] e;
    case (code)
      4'd0:    e = 4'd0;
      4'd1:    e = 4'd7;
      4'd2:    e = 4'd8;
      default: e = code - 4'd1;
    endcase
    return e;
  endfunction

endpackage

// File: rtl/rtc_irq_divider.sv
module rtc_irq_divider
  import rtc_irq_pkg::*;
#(
  parameter int CNT_W   = 15,
  parameter int SEL_W   = 3,
  parameter logic [SEL_W-1:0] RUN_SEL = 3'b010
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              base_tick,
  input  logic [SEL_W-1:0]  div_sel,
  input  logic [RATE_W-1:0] rate_code,
  output logic              running,
  output logic              per_pulse,
  output logic              half_pulse
);

  logic [CNT_W-1:0] cnt;
  logic [EXP_W-1:0] exp_n;
  logic [CNT_W-1:0] full_mask;
  logic [CNT_W-1:0] half_mask;
  logic             rate_on;
  logic             per_hit;
  logic             half_hit;

  assign running = (div_sel == RUN_SEL);
  assign rate_on = (rate_code != '0);

  always_comb begin
    exp_n     = rate_exp(rate_code);
    full_mask = (CNT_W'(1) << exp_n) - CNT_W'(1);
    half_mask = (CNT_W'(1) << (exp_n - EXP_W'(1))) - CNT_W'(1);
    per_hit   = base_tick && running && rate_on && ((cnt & full_mask) == full_mask);
    half_hit  = base_tick && running && rate_on && ((cnt & half_mask) == half_mask);
  end

  always_ff @(posedge clk) begin
    if (rst || !running) begin
      cnt <= '0;
    end else if (base_tick) begin
      cnt <= cnt + CNT_W'(1);
    end
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      per_pulse  <= 1'b0;
      half_pulse <= 1'b0;
    end else begin
      per_pulse  <= per_hit;
      half_pulse <= half_hit;
    end
  end

  a_r1_stopped_quiet: assert property (@(posedge clk) disable iff (rst)
    !running |=> (!per_pulse && !half_pulse && cnt == '0));

  a_r2_code_zero_quiet: assert property (@(posedge clk) disable iff (rst)
    (rate_code == '0) |=> !per_pulse);

  a_r3_period_on_half: assert property (@(posedge clk) disable iff (rst)
    per_pulse |-> half_pulse);

endmodule

// File: rtl/rtc_irq_sqw.sv
module rtc_irq_sqw
  import rtc_irq_pkg::*;
(
  input  logic              clk,
  input  logic              rst,
  input  logic              sqw_en,
  input  logic              running,
  input  logic [RATE_W-1:0] rate_code,
  input  logic              half_pulse,
  output logic              sqw
);

  logic allowed;
  assign allowed = sqw_en && running && (rate_code != '0);

  always_ff @(posedge clk) begin
    if (rst || !allowed) begin
      sqw <= 1'b0;
    end else if (half_pulse) begin
      sqw <= ~sqw;
    end
  end

  a_r9_disabled_low: assert property (@(posedge clk) disable iff (rst)
    !sqw_en |=> !sqw);

  a_r9_toggle_only_on_half: assert property (@(posedge clk) disable iff (rst)
    (allowed && !half_pulse) |=> $stable(sqw));

endmodule

// File: rtl/rtc_irq_flags.sv
module rtc_irq_flags
  import rtc_irq_pkg::*;
(
  input  logic       clk,
  input  logic       rst,
  input  logic       per_pulse,
  input  logic       alarm_evt,
  input  logic       update_evt,
  input  logic       per_en,
  input  logic       alm_en,
  input  logic       upd_en,
  input  logic       flag_rd,
  output evt_flags_t flags,
  output logic       irq
);

  evt_flags_t nxt;
  evt_flags_t ena;

  always_comb begin
    nxt     = flag_rd ? '0 : flags;
    nxt.per = nxt.per | per_pulse;
    nxt.alm = nxt.alm | alarm_evt;
    nxt.upd = nxt.upd | update_evt;
    ena     = '{per: per_en, alm: alm_en, upd: upd_en};
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      flags <= '0;
      irq   <= 1'b0;
    end else begin
      flags <= nxt;
      irq   <= |(nxt & ena);
    end
  end

  a_r5_alarm_sticky: assert property (@(posedge clk) disable iff (rst)
    (flags.alm && !flag_rd) |=> flags.alm);

  a_r5_update_sticky: assert property (@(posedge clk) disable iff (rst)
    (flags.upd && !flag_rd) |=> flags.upd);

  a_r6_irq_has_source: assert property (@(posedge clk) disable iff (rst)
    irq |-> (flags != '0));

  a_r6_alarm_raises: assert property (@(posedge clk) disable iff (rst)
    (alarm_evt && alm_en) |=> irq);

  a_r8_read_clears: assert property (@(posedge clk) disable iff (rst)
    (flag_rd && !per_pulse && !alarm_evt && !update_evt) |=> (flags == '0 && !irq));

  a_r8_event_kept: assert property (@(posedge clk) disable iff (rst)
    (flag_rd && alarm_evt) |=> flags.alm);

endmodule

// File: rtl/rtc_irq_unit.sv
module rtc_irq_unit
  import rtc_irq_pkg::*;
#(
  parameter int CNT_W = 15,
  parameter int SEL_W = 3,
  parameter logic [SEL_W-1:0] RUN_SEL = 3'b010
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              base_tick,
  input  logic              alarm_evt,
  input  logic              update_evt,
  input  logic [SEL_W-1:0]  div_sel,
  input  logic [RATE_W-1:0] rate_code,
  input  logic              per_en,
  input  logic              alm_en,
  input  logic              upd_en,
  input  logic              sqw_en,
  input  logic              flag_rd,
  output logic [7:0]        flag_reg,
  output logic              irq,
  output logic              sqw
);

  logic       running;
  logic       per_pulse;
  logic       half_pulse;
  evt_flags_t flags;

  rtc_irq_divider #(
    .CNT_W   (CNT_W),
    .SEL_W   (SEL_W),
    .RUN_SEL (RUN_SEL)
  ) u_div (
    .clk        (clk),
    .rst        (rst),
    .base_tick  (base_tick),
    .div_sel    (div_sel),
    .rate_code  (rate_code),
    .running    (running),
    .per_pulse  (per_pulse),
    .half_pulse (half_pulse)
  );

  rtc_irq_sqw u_sqw (
    .clk        (clk),
    .rst        (rst),
    .sqw_en     (sqw_en),
    .running    (running),
    .rate_code  (rate_code),
    .half_pulse (half_pulse),
    .sqw        (sqw)
  );

  rtc_irq_flags u_flags (
    .clk        (clk),
    .rst        (rst),
    .per_pulse  (per_pulse),
    .alarm_evt  (alarm_evt),
    .update_evt (update_evt),
    .per_en     (per_en),
    .alm_en     (alm_en),
    .upd_en     (upd_en),
    .flag_rd    (flag_rd),
    .flags      (flags),
    .irq        (irq)
  );

  assign flag_reg = {irq, flags.per, flags.alm, flags.upd, 4'b0000};

  a_r7_low_nibble_zero: assert property (@(posedge clk) disable iff (rst)
    $past(flag_rd) |-> (flag_reg[3:0] == 4'b0000));

endmodule

// File: tb/rtc_irq_unit_test.sv
`timescale 1ns/1ps
module rtc_irq_unit_test;

  logic       clk = 1'b0;
  logic       rst = 1'b1;
  logic       base_tick = 1'b0;
  logic       alarm_evt = 1'b0;
  logic       update_evt = 1'b0;
  logic [2:0] div_sel = 3'b010;
  logic [3:0] rate_code = 4'd0;
  logic       per_en = 1'b0;
  logic       alm_en = 1'b0;
  logic       upd_en = 1'b0;
  logic       sqw_en = 1'b0;
  logic       flag_rd = 1'b0;
  logic [7:0] flag_reg;
  logic       irq;
  logic       sqw;

  int checks = 0;
  int errors = 0;
  logic [7:0] exp_q[$];
  string      tag_q[$];

  always #2.5 clk = ~clk;

  rtc_irq_unit uut (
    .clk(clk), .rst(rst), .base_tick(base_tick), .alarm_evt(alarm_evt),
    .update_evt(update_evt), .div_sel(div_sel), .rate_code(rate_code),
    .per_en(per_en), .alm_en(alm_en), .upd_en(upd_en), .sqw_en(sqw_en),
    .flag_rd(flag_rd), .flag_reg(flag_reg), .irq(irq), .sqw(sqw)
  );

  task automatic check(input string tag, input logic [7:0] act, input logic [7:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s actual=%02h expected=%02h", tag, act, exp);
    end
  endtask

  // Scoreboard driver: queue the expected byte and pulse the read strobe.
  task automatic read_flags(input logic [7:0] exp, input string tag);
    @(negedge clk);
    exp_q.push_back(exp);
    tag_q.push_back(tag);
    flag_rd = 1'b1;
    @(negedge clk);
    flag_rd = 1'b0;
  endtask

  // Monitor: compare the byte presented during each read cycle.
  initial begin
    forever begin
      @(negedge clk);
      #1;
      if (flag_rd) begin
        if (exp_q.size() == 0) begin
          check("scoreboard_empty", 8'h01, 8'h00);
        end else begin
          check(tag_q.pop_front(), flag_reg, exp_q.pop_front());
        end
      end
    end
  end

  task automatic ticks(input int n);
    for (int i = 0; i < n; i++) begin
      @(negedge clk); base_tick = 1'b1;
      @(negedge clk); base_tick = 1'b0;
      @(negedge clk);
    end
  endtask

  task automatic restart_div();
    @(negedge clk); div_sel = 3'b000;
    @(negedge clk); div_sel = 3'b010;
  endtask

  task automatic period_case(input logic [3:0] code, input int period, input string tag);
    rate_code = code;
    restart_div();
    ticks(period - 1);
    read_flags(8'h00, {tag, "_before"});
    ticks(1);
    read_flags(8'h40, {tag, "_on"});
  endtask

  initial begin
    #900000;
    checks++;
    errors++;
    $display("FAIL watchdog actual=running expected=finished");
    $display("  CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  initial begin
    repeat (3) @(negedge clk);
    rst = 1'b0;
    @(negedge clk);
    check("R10_reset_flags", flag_reg, 8'h00);
    check("R10_reset_irq", {7'b0, irq}, 8'h00);
    check("R10_reset_sqw", {7'b0, sqw}, 8'h00);

    // R2: code 0 never fires
    rate_code = 4'd0;
    ticks(64);
    read_flags(8'h00, "R2_code0_silent");

    // R1: stopped divider
    rate_code = 4'd3;
    div_sel = 3'b000;
    ticks(8);
    read_flags(8'h00, "R1_stopped_silent");
    div_sel = 3'b110;
    ticks(8);
    read_flags(8'h00, "R1_other_sel_silent");

    // R3: power-of-two periods
    period_case(4'd3, 4, "R3_code3");
    period_case(4'd6, 32, "R3_code6");
    period_case(4'd15, 16384, "R3_code15");
    // R4: folded codes
    period_case(4'd1, 128, "R4_code1");
    period_case(4'd2, 256, "R4_code2");

    // R6: periodic with enable gives bit7 and irq
    per_en = 1'b1;
    rate_code = 4'd3;
    restart_div();
    ticks(4);
    check("R6_irq_periodic", {7'b0, irq}, 8'h01);
    read_flags(8'hC0, "R6_periodic_enabled");
    @(negedge clk);
    check("R8_irq_cleared", {7'b0, irq}, 8'h00);
    per_en = 1'b0;
    div_sel = 3'b000;

    // R5/R6: alarm flag without enable, then enable later
    @(negedge clk); alarm_evt = 1'b1;
    @(negedge clk); alarm_evt = 1'b0;
    @(negedge clk);
    check("R5_alarm_no_irq", {7'b0, irq}, 8'h00);
    repeat (5) @(negedge clk);
    alm_en = 1'b1;
    @(negedge clk);
    check("R6_late_enable_irq", {7'b0, irq}, 8'h01);
    read_flags(8'hA0, "R5_alarm_sticky");
    alm_en = 1'b0;

    // R5: update flag, enable off
    @(negedge clk); update_evt = 1'b1;
    @(negedge clk); update_evt = 1'b0;
    read_flags(8'h10, "R5_update_flag");
    upd_en = 1'b1;
    @(negedge clk); update_evt = 1'b1;
    @(negedge clk); update_evt = 1'b0;
    read_flags(8'h90, "R6_update_enabled");
    upd_en = 1'b0;

    // R8: event in the read cycle is kept
    @(negedge clk);
    exp_q.push_back(8'h00);
    tag_q.push_back("R8_read_with_event");
    flag_rd = 1'b1;
    alarm_evt = 1'b1;
    @(negedge clk);
    flag_rd = 1'b0;
    alarm_evt = 1'b0;
    read_flags(8'h20, "R8_event_kept");
    read_flags(8'h00, "R8_cleared");

    // R9: square wave, code 3 (toggle every 2 ticks)
    rate_code = 4'd3;
    sqw_en = 1'b1;
    restart_div();
    ticks(1);
    check("R9_sqw_tick1", {7'b0, sqw}, 8'h00);
    ticks(1);
    check("R9_sqw_tick2", {7'b0, sqw}, 8'h01);
    ticks(1);
    check("R9_sqw_tick3", {7'b0, sqw}, 8'h01);
    ticks(1);
    check("R9_sqw_tick4", {7'b0, sqw}, 8'h00);
    ticks(2);
    check("R9_sqw_tick6", {7'b0, sqw}, 8'h01);
    sqw_en = 1'b0;
    @(negedge clk);
    check("R9_sqw_disabled_low", {7'b0, sqw}, 8'h00);
    sqw_en = 1'b1;
    rate_code = 4'd0;
    ticks(8);
    check("R9_sqw_code0_low", {7'b0, sqw}, 8'h00);
    sqw_en = 1'b0;
    read_flags(8'h40, "R7_nibble_zero_after_sqw");

    repeat (3) @(negedge clk);
    check("scoreboard_drained", 8'(exp_q.size()), 8'h00);
    $display("  CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

endmodule